// File: doc/BRIEF.md
# Priority Pin Function Multiplexer

This block decides, for each of a small set of package pins, which functional signal owns the pin. Software programs three 32-bit configuration words over a simple register bus. A fourth word holds a strap value. The strap is captured from an input port while reset is held, and the bus can read it but never write it. Every pin carries a fixed table of up to five priority levels, where level 0 is the strongest. A level is enabled by an OR of expressions. Each expression is an AND of field comparisons against the configuration and strap words. For every comparison, the field is taken from the chosen word, shifted down to its low bit, masked to its width, and compared with a constant.

For each pin, the winner is the lowest-numbered level whose enable is true. If no level is enabled, the pin falls back to its "other" function, which has code 5. The choice is registered and presented two ways, as a binary code and as a one-hot vector. The registered choice also steers one of six functional inputs of that pin onto its pad output. The tables are fixed when the design is elaborated. Integration consists of writing configuration words and wiring the functional signals and pad outputs.

Top module: `prio_pin_mux`

## Requirements
- R1: While `rst_ni` is low at a rising clock edge, all three configuration words are cleared and `strap_i` is latched as the strap word. Once reset is released, each pin shows the selection its table yields for that state.
- R2: A bus write with `bus_we_i` high to address 0, 1 or 2 updates configuration word CFG0, CFG1 or CFG2 at that clock edge. `bus_rdata_o` combinationally returns the word selected by `bus_addr_i`, and address 3 returns the strap word.
- R3: A write to address 3 is ignored. The strap word and every pin selection stay as they were.
- R4: A comparison matches when (word >> lsb) masked to its field width equals its constant. An expression holds only if all of its comparisons match, and mixed polarities are allowed.
- R5: When a level has several expressions, any one of them that holds enables the level.
- R6: The selected code is the lowest-numbered enabled level.
- R7: If no level of a pin is enabled, that pin's code is 5, the other function.
- R8: `sel_onehot_o` for each pin has exactly one bit set, namely the bit at that pin's code.
- R9: A configuration change written at clock edge N appears on the selection outputs after edge N+1 and not before.
- R10: `pad_o[p]` equals `func_sig_i[p*6 + code]`, where code is pin p's current selection.
- R11: Pin tables, part 1. Pin 0 uses level 0 when CFG0[0]=1. Pin 1 uses level 0 when CFG1[22]=1 and level 1 when CFG0[4]=1. Pin 2 uses level 0 when CFG0[12]=1 or strap[14]=1.
- R12: Pin tables, part 2. Pin 3 uses level 0 when CFG2[3]=1, CFG0[15]=1 and CFG1[31]=0, and level 1 when the same two bits are set with CFG1[31]=1. Pin 4 uses level 0 when CFG1[5:4] is 1, 2 or 3 and CFG0[17]=1, and level 1 when CFG0[17]=1. Pin 5 uses level 0 when CFG1[5:4]=3 and CFG0[22]=1, and level 1 when CFG0[22]=1.
- R13: Pin 6 uses four levels:
  - level 0 when CFG0[25]=1;
  - level 1 when CFG2[12]=1 or strap[19]=0;
  - level 2 when CFG2[0]=1;
  - level 4 when CFG2[1]=1.
  
  Level 3 of pin 6 is never enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset; strap is captured while low |
| strap_i | input | 32 | Strap value sampled during reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address (0..2 configuration, 3 strap) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| func_sig_i | input | 42 | Six functional signals per pin, index p*6+code |
| sel_code_o | output | 21 | Registered 3-bit selection code per pin |
| sel_onehot_o | output | 42 | Registered one-hot selection, 6 bits per pin |
| pad_o | output | 7 | Routed pad value per pin |

## Verification
The assertions hold on every cycle for several properties:
- the one-hot vector agrees with the code;
- the pad follows the input at the selected index;
- the strap word never moves after reset;
- a written word reads back as written;
- stable configuration keeps the selection stable one cycle later;
- pin 0's level-0 or fallback choice follows CFG0[0] with one cycle of delay.

The bench scenarios cover what needs a model of the whole table. This includes the mixed-polarity flip on pin 3, the four video-mode values on pins 4 and 5, strap-driven OR terms, the five-level ordering on pin 6, the exact latency edge, and write attempts to the strap address.

// File: rtl/pm_pkg.sv
package pm_pkg;

   // Fixed table limits
   localparam int TBL_PINS   = 7;
   localparam int TBL_LVLS   = 5;
   localparam int TBL_EXPR   = 3;
   localparam int TBL_DESC   = 3;
   localparam int TBL_SRCS   = 4;   // three config words plus strap
   localparam int TBL_MIN_DW = 32;

   // Source indices of the comparison words
   localparam int SRC_CFG0  = 0;
   localparam int SRC_CFG1  = 1;
   localparam int SRC_CFG2  = 2;
   localparam int SRC_STRAP = 3;

   typedef struct packed {
      logic       vld;
      logic [1:0] src;
      logic [4:0] lsb;
      logic [1:0] wid;
      logic [1:0] val;
   } pm_cmp_t;

   function automatic pm_cmp_t mk(int s, int b, int w, int v);
      pm_cmp_t r;
      r.vld = 1'b1;
      r.src = 2'(s);
      r.lsb = 5'(b);
      r.wid = 2'(w);
      r.val = 2'(v);
      return r;
   endfunction

   // Comparison d of expression ex at level lvl of pin.
   // A result with vld = 0 means the slot is unused.
   function automatic pm_cmp_t tbl_cmp(int pin, int lvl, int ex, int d);
      pm_cmp_t r = '0;
      case (pin)
         0: if (lvl == 0 && ex == 0 && d == 0) r = mk(SRC_CFG0, 0, 1, 1);
         1: if (ex == 0 && d == 0) begin
               if (lvl == 0)      r = mk(SRC_CFG1, 22, 1, 1);
               else if (lvl == 1) r = mk(SRC_CFG0, 4, 1, 1);
            end
         2: if (lvl == 0 && d == 0) begin
               if (ex == 0)      r = mk(SRC_CFG0, 12, 1, 1);
               else if (ex == 1) r = mk(SRC_STRAP, 14, 1, 1);
            end
         3: if (lvl < 2 && ex == 0) begin
               if (d == 0)      r = mk(SRC_CFG2, 3, 1, 1);
               else if (d == 1) r = mk(SRC_CFG0, 15, 1, 1);
               else if (d == 2) r = mk(SRC_CFG1, 31, 1, (lvl == 1) ? 1 : 0);
            end
         4: if (lvl == 0 && d == 0)      r = mk(SRC_CFG1, 4, 2, ex + 1);
            else if (lvl == 0 && d == 1) r = mk(SRC_CFG0, 17, 1, 1);
            else if (lvl == 1 && ex == 0 && d == 0) r = mk(SRC_CFG0, 17, 1, 1);
         5: if (lvl == 0 && ex == 0 && d == 0)      r = mk(SRC_CFG1, 4, 2, 3);
            else if (lvl == 0 && ex == 0 && d == 1) r = mk(SRC_CFG0, 22, 1, 1);
            else if (lvl == 1 && ex == 0 && d == 0) r = mk(SRC_CFG0, 22, 1, 1);
         6: if (d == 0) begin
               if (lvl == 0 && ex == 0)      r = mk(SRC_CFG0, 25, 1, 1);
               else if (lvl == 1 && ex == 0) r = mk(SRC_CFG2, 12, 1, 1);
               else if (lvl == 1 && ex == 1) r = mk(SRC_STRAP, 19, 1, 0);
               else if (lvl == 2 && ex == 0) r = mk(SRC_CFG2, 0, 1, 1);
               else if (lvl == 4 && ex == 0) r = mk(SRC_CFG2, 1, 1, 1);
            end
         default: r = '0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pm_regbank.sv
module pm_regbank #(
   parameter int DW       = 32,
   parameter int NUM_CTRL = 3,
   parameter int ADDR_W   = 2
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic [DW-1:0]              strap_i,
   input  logic                       we_i,
   input  logic [ADDR_W-1:0]          addr_i,
   input  logic [DW-1:0]              wdata_i,
   output logic [(NUM_CTRL+1)*DW-1:0] bank_o,
   output logic [DW-1:0]              rdata_o
);

   localparam int NUM_SRC = NUM_CTRL + 1;

   logic [DW-1:0] strap_q;

   for (genvar r = 0; r < NUM_CTRL; r++) begin : g_cfg
      logic [DW-1:0] q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni)                               q <= '0;
         else if (we_i && addr_i == ADDR_W'(r))     q <= wdata_i;
      end
      assign bank_o[r*DW +: DW] = q;
   end

   // Strap word: loaded only during reset, no bus write path
   always_ff @(posedge clk_i) begin
      if (!rst_ni) strap_q <= strap_i;
   end
   assign bank_o[NUM_CTRL*DW +: DW] = strap_q;

   always_comb begin
      rdata_o = '0;
      for (int r = 0; r < NUM_SRC; r++) begin
         if (addr_i == ADDR_W'(r)) rdata_o = bank_o[r*DW +: DW];
      end
   end

endmodule

// File: rtl/pm_pin_eval.sv
module pm_pin_eval
   import pm_pkg::*;
#(
   parameter int PIN      = 0,
   parameter int NUM_LVL  = 5,
   parameter int NUM_EXPR = 3,
   parameter int NUM_DESC = 3,
   parameter int DW       = 32,
   parameter int NUM_SRC  = 4
) (
   input  logic [NUM_SRC*DW-1:0] bank_i,
   output logic [NUM_LVL-1:0]    lvl_hit_o
);

   localparam int EXD = NUM_EXPR * NUM_DESC;

   logic [NUM_LVL*EXD-1:0]      cmp_ok;
   logic [NUM_LVL*NUM_EXPR-1:0] expr_true;
   logic                        unused_bank;

   assign unused_bank = ^bank_i;

   for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
      for (genvar e = 0; e < NUM_EXPR; e++) begin : g_expr
         localparam pm_cmp_t LEAD = tbl_cmp(PIN, l, e, 0);
         for (genvar d = 0; d < NUM_DESC; d++) begin : g_cmp
            localparam pm_cmp_t C = tbl_cmp(PIN, l, e, d);
            if (C.vld) begin : g_live
               // Extract field at lsb, mask to width, compare with constant
               assign cmp_ok[l*EXD + e*NUM_DESC + d] =
                  (((bank_i[int'(C.src)*DW +: DW] >> C.lsb)
                    & ((DW'(1) << C.wid) - DW'(1))) == DW'(C.val));
            end else begin : g_idle
               assign cmp_ok[l*EXD + e*NUM_DESC + d] = 1'b1;
            end
         end
         if (LEAD.vld) begin : g_used
            assign expr_true[l*NUM_EXPR + e] = &cmp_ok[l*EXD + e*NUM_DESC +: NUM_DESC];
         end else begin : g_void
            assign expr_true[l*NUM_EXPR + e] = 1'b0;
         end
      end
      assign lvl_hit_o[l] = |expr_true[l*NUM_EXPR +: NUM_EXPR];
   end

endmodule

// File: rtl/pm_prio_pick.sv
module pm_prio_pick #(
   parameter int NUM_LVL = 5,
   parameter int CODE_W  = 3
) (
   input  logic               clk_i,
   input  logic [NUM_LVL-1:0] lvl_hit_i,
   input  logic [NUM_LVL:0]   func_i,
   output logic [CODE_W-1:0]  code_o,
   output logic [NUM_LVL:0]   onehot_o,
   output logic               pad_o
);

   logic [NUM_LVL:0]  blocked;
   logic [NUM_LVL:0]  oh_d;
   logic [CODE_W-1:0] code_d;

   // One-hot through a prefix chain of stronger hits
   assign blocked[0] = 1'b0;
   for (genvar i = 0; i < NUM_LVL; i++) begin : g_chain
      assign blocked[i+1] = blocked[i] | lvl_hit_i[i];
      assign oh_d[i]      = lvl_hit_i[i] & ~blocked[i];
   end
   assign oh_d[NUM_LVL] = ~blocked[NUM_LVL];

   // Binary code through a reverse scan
   always_comb begin
      code_d = CODE_W'(NUM_LVL);
      for (int i = NUM_LVL - 1; i >= 0; i--) begin
         if (lvl_hit_i[i]) code_d = CODE_W'(i);
      end
   end

   always_ff @(posedge clk_i) begin
      code_o   <= code_d;
      onehot_o <= oh_d;
   end

   assign pad_o = |(onehot_o & func_i);

endmodule

// File: rtl/prio_pin_mux.sv
module prio_pin_mux
   import pm_pkg::*;
#(
   parameter int DW       = 32,
   parameter int NUM_CTRL = 3,
   parameter int ADDR_W   = 2,
   parameter int NUM_PINS = 7,
   parameter int NUM_LVL  = 5,
   parameter int NUM_EXPR = 3,
   parameter int NUM_DESC = 3,
   parameter int CODE_W   = 3
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic [DW-1:0]                 strap_i,
   input  logic                          bus_we_i,
   input  logic [ADDR_W-1:0]             bus_addr_i,
   input  logic [DW-1:0]                 bus_wdata_i,
   output logic [DW-1:0]                 bus_rdata_o,
   input  logic [NUM_PINS*(NUM_LVL+1)-1:0] func_sig_i,
   output logic [NUM_PINS*CODE_W-1:0]    sel_code_o,
   output logic [NUM_PINS*(NUM_LVL+1)-1:0] sel_onehot_o,
   output logic [NUM_PINS-1:0]           pad_o
);

   localparam int NUM_SRC = NUM_CTRL + 1;
   localparam int SEL_W   = NUM_LVL + 1;

   if (DW < TBL_MIN_DW) begin : g_bad_dw
      $error("DW too narrow for table bit positions");
   end
   if (NUM_SRC != TBL_SRCS) begin : g_bad_src
      $error("NUM_CTRL does not match table sources");
   end
   if (NUM_PINS > TBL_PINS || NUM_LVL > TBL_LVLS) begin : g_bad_dim
      $error("pin or level count exceeds table");
   end
   if (NUM_EXPR > TBL_EXPR || NUM_DESC > TBL_DESC) begin : g_bad_expr
      $error("expression dimensions exceed table");
   end
   if ((1 << ADDR_W) < NUM_SRC) begin : g_bad_aw
      $error("ADDR_W cannot address all words");
   end
   if ((1 << CODE_W) <= NUM_LVL) begin : g_bad_cw
      $error("CODE_W cannot hold the fallback code");
   end

   logic [NUM_SRC*DW-1:0] bank_w;

   pm_regbank #(
      .DW       (DW),
      .NUM_CTRL (NUM_CTRL),
      .ADDR_W   (ADDR_W)
   ) i_regbank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .strap_i (strap_i),
      .we_i    (bus_we_i),
      .addr_i  (bus_addr_i),
      .wdata_i (bus_wdata_i),
      .bank_o  (bank_w),
      .rdata_o (bus_rdata_o)
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic [NUM_LVL-1:0] hit;

      pm_pin_eval #(
         .PIN      (p),
         .NUM_LVL  (NUM_LVL),
         .NUM_EXPR (NUM_EXPR),
         .NUM_DESC (NUM_DESC),
         .DW       (DW),
         .NUM_SRC  (NUM_SRC)
      ) i_eval (
         .bank_i    (bank_w),
         .lvl_hit_o (hit)
      );

      pm_prio_pick #(
         .NUM_LVL (NUM_LVL),
         .CODE_W  (CODE_W)
      ) i_pick (
         .clk_i     (clk_i),
         .lvl_hit_i (hit),
         .func_i    (func_sig_i[p*SEL_W +: SEL_W]),
         .code_o    (sel_code_o[p*CODE_W +: CODE_W]),
         .onehot_o  (sel_onehot_o[p*SEL_W +: SEL_W]),
         .pad_o     (pad_o[p])
      );
   end

endmodule

// File: rtl/prio_pin_mux_chk.sv
module prio_pin_mux_chk #(
   parameter int DW       = 32,
   parameter int NUM_CTRL = 3,
   parameter int ADDR_W   = 2,
   parameter int NUM_PINS = 7,
   parameter int NUM_LVL  = 5,
   parameter int CODE_W   = 3
) (
   input logic                            clk_i,
   input logic                            rst_ni,
   input logic                            we_i,
   input logic [ADDR_W-1:0]               addr_i,
   input logic [DW-1:0]                   wdata_i,
   input logic [(NUM_CTRL+1)*DW-1:0]      bank_i,
   input logic [NUM_PINS*(NUM_LVL+1)-1:0] func_i,
   input logic [NUM_PINS*CODE_W-1:0]      code_i,
   input logic [NUM_PINS*(NUM_LVL+1)-1:0] onehot_i,
   input logic [NUM_PINS-1:0]             pad_i
);

   localparam int SEL_W = NUM_LVL + 1;

   logic [ADDR_W-1:0] addr_q;
   logic [DW-1:0]     word_at_q;

   always_ff @(posedge clk_i) addr_q <= addr_i;
   assign word_at_q = bank_i[int'(addr_q)*DW +: DW];

   // R2
   wr_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(we_i) && $past(addr_i) < ADDR_W'(NUM_CTRL))
      |-> word_at_q == $past(wdata_i));

   // R3
   strap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> $stable(bank_i[NUM_CTRL*DW +: DW]));

   // R9
   latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $stable(bank_i)) |=> ($stable(code_i) && $stable(onehot_i)));

   // R6
   pin0_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(bank_i[0])) |-> code_i[CODE_W-1:0] == '0);

   // R7
   pin0_other_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && !$past(bank_i[0])) |-> code_i[CODE_W-1:0] == CODE_W'(NUM_LVL));

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      // R8
      onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $past(rst_ni) |-> (code_i[p*CODE_W +: CODE_W] <= CODE_W'(NUM_LVL)
            && onehot_i[p*SEL_W +: SEL_W] == (SEL_W'(1) << code_i[p*CODE_W +: CODE_W])));

      // R10
      pad_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ($past(rst_ni) && code_i[p*CODE_W +: CODE_W] <= CODE_W'(NUM_LVL))
         |-> pad_i[p] == func_i[p*SEL_W + int'(code_i[p*CODE_W +: CODE_W])]);
   end

endmodule

bind prio_pin_mux prio_pin_mux_chk #(
   .DW       (DW),
   .NUM_CTRL (NUM_CTRL),
   .ADDR_W   (ADDR_W),
   .NUM_PINS (NUM_PINS),
   .NUM_LVL  (NUM_LVL),
   .CODE_W   (CODE_W)
) i_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .we_i     (bus_we_i),
   .addr_i   (bus_addr_i),
   .wdata_i  (bus_wdata_i),
   .bank_i   (bank_w),
   .func_i   (func_sig_i),
   .code_i   (sel_code_o),
   .onehot_i (sel_onehot_o),
   .pad_i    (pad_o)
);

// File: tb/test_prio_pin_mux.sv
`timescale 1ns/1ps
module test_prio_pin_mux;

   localparam int DW = 32;
   localparam int NC = 3;
   localparam int AW = 2;
   localparam int NP = 7;
   localparam int NL = 5;
   localparam int CW = 3;
   localparam int SW = NL + 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [DW-1:0]     strap;
   logic              we;
   logic [AW-1:0]     addr;
   logic [DW-1:0]     wdata;
   logic [DW-1:0]     rdata;
   logic [NP*SW-1:0]  func;
   logic [NP*CW-1:0]  code;
   logic [NP*SW-1:0]  onehot;
   logic [NP-1:0]     pad;

   int n_chk = 0;
   int n_bad = 0;
   logic [DW-1:0] sh [0:NC-1];
   logic [DW-1:0] sh_st;

   always #2.5 clk = ~clk;

   prio_pin_mux i_prio_pin_mux (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .strap_i      (strap),
      .bus_we_i     (we),
      .bus_addr_i   (addr),
      .bus_wdata_i  (wdata),
      .bus_rdata_o  (rdata),
      .func_sig_i   (func),
      .sel_code_o   (code),
      .sel_onehot_o (onehot),
      .pad_o        (pad)
   );

   // Reference selection from the pin tables (R11, R12, R13)
   function automatic int ref_code(int p, logic [31:0] c0, logic [31:0] c1,
                                   logic [31:0] c2, logic [31:0] st);
      case (p)
         0: return c0[0] ? 0 : 5;
         1: return c1[22] ? 0 : (c0[4] ? 1 : 5);
         2: return (c0[12] || st[14]) ? 0 : 5;
         3: return (c2[3] && c0[15]) ? (c1[31] ? 1 : 0) : 5;
         4: return (c0[17] && c1[5:4] != 2'd0) ? 0 : (c0[17] ? 1 : 5);
         5: return (c0[22] && c1[5:4] == 2'd3) ? 0 : (c0[22] ? 1 : 5);
         6: begin
            if (c0[25]) return 0;
            if (c2[12] || !st[19]) return 1;
            if (c2[0]) return 2;
            if (c2[1]) return 4;
            return 5;
         end
         default: return 5;
      endcase
   endfunction

   function automatic string tag_of(int p);
      if (p < 3) return "R11";
      if (p < 6) return "R12";
      return "R13";
   endfunction

   task automatic chk(string req, string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic check_pin(string req, int p, int e);
      chk(req, $sformatf("pin%0d code", p), longint'(code[p*CW +: CW]), longint'(e));
   endtask

   task automatic check_pins(string req);
      for (int p = 0; p < NP; p++) begin
         int e;
         e = ref_code(p, sh[0], sh[1], sh[2], sh_st);
         check_pin((req == "") ? tag_of(p) : req, p, e);
         chk("R8", $sformatf("pin%0d onehot", p),
             longint'(onehot[p*SW +: SW]), longint'(1 << e));
         chk("R10", $sformatf("pin%0d pad", p),
             longint'(pad[p]), longint'(func[p*SW + e]));
      end
   endtask

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      we = 1'b1;
      addr = AW'(a);
      wdata = d;
      @(negedge clk);
      we = 1'b0;
      if (a < NC) sh[a] = d;
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   task automatic rd_chk(string req, int a, logic [31:0] e);
      addr = AW'(a);
      #1;
      chk(req, $sformatf("rdata[%0d]", a), longint'(rdata), longint'(e));
   endtask

   task automatic do_reset(logic [31:0] st);
      @(negedge clk);
      rst_n = 1'b0;
      strap = st;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      strap = ~st;
      for (int r = 0; r < NC; r++) sh[r] = '0;
      sh_st = st;
   endtask

   task automatic new_func();
      func = (NP*SW)'({$urandom(), $urandom()});
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #1ms;
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'h1D2C3B4A));
      we = 1'b0;
      addr = '0;
      wdata = '0;
      strap = '0;
      new_func();

      // R1: reset state with strap[19]=1, strap[14]=0
      do_reset(32'h0008_0000);
      for (int r = 0; r < NC; r++) rd_chk("R1", r, 32'h0);
      rd_chk("R1", 3, 32'h0008_0000);
      check_pins("R1");

      // R9: no change right after the write edge, change one edge later
      wr(0, 32'h1);
      check_pin("R9", 0, 5);
      settle();
      check_pin("R9", 0, 0);

      // R4: three-term AND with mixed polarity on pin 3
      wr(2, 32'h8);
      wr(0, 32'h1 | (32'h1 << 15));
      settle();
      check_pin("R4", 3, 0);
      wr(1, 32'h8000_0000);
      settle();
      check_pin("R4", 3, 1);
      wr(2, 32'h0);
      settle();
      check_pin("R7", 3, 5);

      // R6: stronger level wins on pin 1
      wr(0, 32'h10);
      wr(1, 32'h0040_0000);
      settle();
      check_pin("R6", 1, 0);
      wr(1, 32'h0);
      settle();
      check_pin("R6", 1, 1);

      // R12: mode field values on pins 4 and 5
      wr(0, (32'h1 << 17) | (32'h1 << 22));
      for (int m = 0; m < 4; m++) begin
         wr(1, 32'(m) << 4);
         settle();
         check_pin("R12", 4, (m != 0) ? 0 : 1);
         check_pin("R12", 5, (m == 3) ? 0 : 1);
      end

      // R3: strap address write ignored
      wr(3, 32'hFFF7_FFFF);
      settle();
      rd_chk("R3", 3, sh_st);
      check_pins("R3");

      // R13: five-level ordering on pin 6, strap[19]=1
      wr(2, 32'h2);
      settle();
      check_pin("R13", 6, 4);
      wr(2, 32'h3);
      settle();
      check_pin("R13", 6, 2);
      wr(2, 32'h1003);
      settle();
      check_pin("R13", 6, 1);
      wr(0, 32'h1 << 25);
      settle();
      check_pin("R13", 6, 0);

      // R5: strap terms in OR with control bits
      do_reset(32'h0000_4000);
      check_pin("R5", 2, 0);
      check_pin("R5", 6, 1);
      wr(0, 32'h1 << 12);
      settle();
      check_pin("R5", 2, 0);
      check_pins("R5");

      // Random sweep over strap and configuration (R2 readback, tables)
      for (int s = 0; s < 4; s++) begin
         logic [31:0] st;
         st = $urandom();
         st[14] = s[0];
         st[19] = s[1];
         do_reset(st);
         check_pins("R1");
         for (int i = 0; i < 60; i++) begin
            int a;
            logic [31:0] d;
            a = int'($urandom() % 4);
            d = $urandom();
            if ($urandom() % 2 == 0) d = d & $urandom();
            wr(a, d);
            new_func();
            settle();
            rd_chk((a < NC) ? "R2" : "R3", a, (a < NC) ? sh[a] : sh_st);
            check_pins("");
         end
      end

      finish_run();
   end

endmodule